// File: doc/BRIEF.md
# Frame Timer with Compare Flags

This block keeps frame time for a bus-schedule sequencer. A down-counting frame counter is loaded by one command and set running by a separate one. While running, it loses one count for every hundred pulses of a 1 µs tick, so one count is 100 µs and a loaded value of 10 gives a 1 ms frame. When the count reaches zero it stops there. It can then raise a one-cycle end-of-frame interrupt. That interrupt lets the timer act as a watchdog: a sequencer that fails to reload it in time gets caught.

The sequencer can stall on the counter until it reaches zero, which gives a wait-for-frame-end step. It can also compare the remaining time against a value. The compare drives two condition flags that the sequencer branches on, so it can decide whether enough frame time is left for optional traffic.

A second, independent counter measures message-to-message and delay intervals at 1 µs per count. It has a 16-bit range, which reaches 65.535 ms. The sequencer loads it and waits while it reports busy.

Top module: `frame_sched_timer`

## Requirements
- R1: After reset the frame count, both condition flags, the interrupt, the delay count and the delay busy output are all zero.
- R2: A frame load strobe sets the frame count to the load value and stops the timer. A stopped timer never changes its count, whatever the tick does. When load and start are asserted in the same cycle, the load value is taken and the timer runs.
- R3: A start strobe runs the timer and clears the prescaler. A tick in the start cycle is not counted. The count then drops by exactly one on each 100th tick (FT_DIV) seen while running, so the first decrement comes a full 100 ticks after start.
- R4: The frame count stops at zero and never wraps. On reaching zero the timer stops running.
- R5: `eof_irq` is high for exactly one cycle, in the cycle after the edge where the count steps from 1 to 0, and only if `eof_irq_en` was high at that edge. Loading zero or running while disabled gives no pulse.
- R6: A compare strobe updates `cmp_flags` in the next cycle, using the count held before that edge. Bit 0 is set when count < compare value. Bit 1 is set when count >= compare value. The flags hold between compares, and a compare works equally on a stopped timer.
- R7: `ft_stall` is high, combinationally, exactly while `ft_wait` is high and the frame count is nonzero.
- R8: A delay load sets the delay count, and the load wins over a tick in the same cycle. Each tick after that lowers a nonzero delay count by one. The delay count stops at zero. `dly_busy` is high exactly while the delay count is nonzero. This counter runs whether or not the frame timer runs.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| us_tick | input | 1 | One-cycle pulse each microsecond |
| ft_load | input | 1 | Frame load strobe |
| ft_load_val | input | FT_W | Frame load value, 100 µs per count |
| ft_start | input | 1 | Frame start strobe |
| ft_wait | input | 1 | Sequencer is waiting for frame end |
| ft_cmp | input | 1 | Compare strobe |
| ft_cmp_val | input | FT_W | Compare value |
| eof_irq_en | input | 1 | End-of-frame interrupt enable |
| dly_load | input | 1 | Delay load strobe |
| dly_val | input | DLY_W | Delay value, 1 µs per count |
| ft_remain | output | FT_W | Current frame count |
| cmp_flags | output | 2 | Bit 0 less-than, bit 1 greater-or-equal |
| ft_stall | output | 1 | Stall request for the sequencer |
| eof_irq | output | 1 | End-of-frame interrupt pulse |
| dly_busy | output | 1 | Delay counter nonzero |
| dly_remain | output | DLY_W | Current delay count |

## Verification
The bench puts ticks on the start cycle and on the 99th and 100th tick after start. A design that counts the start-cycle tick, or does not clear the prescaler, would decrement one tick early. It runs the counter down to zero with the interrupt enabled and disabled, then keeps ticking. A wrapping counter would jump to all ones, and a level-style interrupt would stay high. Compares are issued at equal, adjacent and stopped counts, which separates a strict compare from an inclusive one. The bench also loads the delay counter on a tick cycle and with zero, which shows whether load wins and whether busy drops at once.

// File: rtl/ftm_pkg.sv
package ftm_pkg;
   localparam int FLAG_LT = 0;
   localparam int FLAG_GE = 1;
   localparam int NFLAGS  = 2;
endpackage

// File: rtl/ftm_prescaler.sv
module ftm_prescaler #(
   parameter int DIV = 100
) (
   input  logic clk,
   input  logic rst_n,
   input  logic clr,
   input  logic en,
   input  logic tick,
   output logic step
);
   generate
      if (DIV < 1) begin : g_bad_div
         $error("ftm_prescaler: DIV must be at least 1");
      end
      if (DIV == 1) begin : g_bypass
         assign step = en & tick & ~clr;
      end else begin : g_count
         localparam int PW = $clog2(DIV);
         localparam logic [PW-1:0] LAST = PW'(DIV - 1);
         logic [PW-1:0] pcnt;
         always_ff @(posedge clk) begin
            if (!rst_n)          pcnt <= '0;
            else if (clr)        pcnt <= '0;
            else if (en && tick) pcnt <= (pcnt == LAST) ? '0 : pcnt + 1'b1;
         end
         assign step = en & tick & ~clr & (pcnt == LAST);
         AST_PRE_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
            pcnt <= LAST);                                           // R3
      end
   endgenerate
endmodule

// File: rtl/ftm_downcnt.sv
module ftm_downcnt #(
   parameter int W = 16
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic         load,
   input  logic [W-1:0] load_val,
   input  logic         dec,
   output logic [W-1:0] cnt,
   output logic         nonzero,
   output logic         hits_zero
);
   generate
      if (W < 2) begin : g_bad_w
         $error("ftm_downcnt: W must be at least 2");
      end
   endgenerate

   localparam logic [W-1:0] ONE = W'(1);

   always_ff @(posedge clk) begin
      if (!rst_n)                  cnt <= '0;
      else if (load)               cnt <= load_val;
      else if (dec && cnt != '0)   cnt <= cnt - 1'b1;
   end

   assign nonzero   = (cnt != '0);
   assign hits_zero = dec & ~load & (cnt == ONE);

   AST_NO_WRAP: assert property (@(posedge clk) disable iff (!rst_n)
      (cnt == '0 && !load) |=> cnt == '0);                            // R4
   AST_DEC_ONE: assert property (@(posedge clk) disable iff (!rst_n)
      (dec && !load && cnt != '0) |=> cnt == W'($past(cnt) - ONE));   // R3
endmodule

// File: rtl/ftm_compare.sv
module ftm_compare
   import ftm_pkg::*;
#(
   parameter int W = 16
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              cmp,
   input  logic [W-1:0]      cnt,
   input  logic [W-1:0]      ref_val,
   output logic [NFLAGS-1:0] flags
);
   logic [NFLAGS-1:0] nxt;
   always_comb begin
      nxt          = '0;
      nxt[FLAG_LT] = (cnt <  ref_val);
      nxt[FLAG_GE] = (cnt >= ref_val);
   end

   always_ff @(posedge clk) begin
      if (!rst_n)   flags <= '0;
      else if (cmp) flags <= nxt;
   end

   AST_FLAGS_ONEHOT: assert property (@(posedge clk) disable iff (!rst_n)
      $onehot0(flags));                                                // R6
   AST_FLAGS_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
      !cmp |=> $stable(flags));                                        // R6
endmodule

// File: rtl/frame_sched_timer.sv
module frame_sched_timer
   import ftm_pkg::*;
#(
   parameter int FT_W   = 16,
   parameter int FT_DIV = 100,
   parameter int DLY_W  = 16
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             us_tick,
   input  logic             ft_load,
   input  logic [FT_W-1:0]  ft_load_val,
   input  logic             ft_start,
   input  logic             ft_wait,
   input  logic             ft_cmp,
   input  logic [FT_W-1:0]  ft_cmp_val,
   input  logic             eof_irq_en,
   input  logic             dly_load,
   input  logic [DLY_W-1:0] dly_val,
   output logic [FT_W-1:0]  ft_remain,
   output logic [1:0]       cmp_flags,
   output logic             ft_stall,
   output logic             eof_irq,
   output logic             dly_busy,
   output logic [DLY_W-1:0] dly_remain
);
   generate
      if (NFLAGS != 2) begin : g_bad_flags
         $error("frame_sched_timer: flag width mismatch");
      end
   endgenerate

   logic run_q, step, ft_nz, ft_hit, irq_q, dly_hit_unused;

   ftm_prescaler #(.DIV(FT_DIV)) i_pre (
      .clk(clk), .rst_n(rst_n), .clr(ft_start),
      .en(run_q), .tick(us_tick), .step(step));

   ftm_downcnt #(.W(FT_W)) i_frame (
      .clk(clk), .rst_n(rst_n), .load(ft_load), .load_val(ft_load_val),
      .dec(step), .cnt(ft_remain), .nonzero(ft_nz), .hits_zero(ft_hit));

   ftm_downcnt #(.W(DLY_W)) i_delay (
      .clk(clk), .rst_n(rst_n), .load(dly_load), .load_val(dly_val),
      .dec(us_tick), .cnt(dly_remain), .nonzero(dly_busy),
      .hits_zero(dly_hit_unused));

   ftm_compare #(.W(FT_W)) i_cmp (
      .clk(clk), .rst_n(rst_n), .cmp(ft_cmp), .cnt(ft_remain),
      .ref_val(ft_cmp_val), .flags(cmp_flags));

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         run_q <= 1'b0;
         irq_q <= 1'b0;
      end else begin
         if (ft_load)       run_q <= ft_start;
         else if (ft_start) run_q <= 1'b1;
         else if (ft_hit)   run_q <= 1'b0;
         irq_q <= eof_irq_en & ft_hit;
      end
   end

   assign eof_irq  = irq_q;
   assign ft_stall = ft_wait & ft_nz;

   AST_IRQ_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
      eof_irq |=> !eof_irq);                                           // R5
   AST_IRQ_AT_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
      eof_irq |-> ft_remain == '0);                                    // R5
   AST_HOLD_STOPPED: assert property (@(posedge clk) disable iff (!rst_n)
      (!run_q && !ft_load) |=> $stable(ft_remain));                    // R2
endmodule

// File: tb/test_frame_sched_timer.sv
module test_frame_sched_timer;
   localparam int FT_W = 16, FT_DIV = 100, DLY_W = 16;

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   logic us_tick = 0, ft_load = 0, ft_start = 0, ft_wait = 0, ft_cmp = 0;
   logic eof_irq_en = 0, dly_load = 0;
   logic [FT_W-1:0]  ft_load_val = '0, ft_cmp_val = '0;
   logic [DLY_W-1:0] dly_val = '0;
   logic [FT_W-1:0]  ft_remain;
   logic [1:0]       cmp_flags;
   logic             ft_stall, eof_irq, dly_busy;
   logic [DLY_W-1:0] dly_remain;

   int tests = 0, fails = 0;
   bit done = 0;

   // reference model state
   int m_cnt = 0, m_pre = 0, m_dly = 0;
   bit m_run = 0, m_irq = 0;
   bit [1:0] m_flags = 2'b00;

   always #2 clk = ~clk;

   frame_sched_timer #(.FT_W(FT_W), .FT_DIV(FT_DIV), .DLY_W(DLY_W)) i_frame_sched_timer (
      .clk(clk), .rst_n(rst_n), .us_tick(us_tick), .ft_load(ft_load),
      .ft_load_val(ft_load_val), .ft_start(ft_start), .ft_wait(ft_wait),
      .ft_cmp(ft_cmp), .ft_cmp_val(ft_cmp_val), .eof_irq_en(eof_irq_en),
      .dly_load(dly_load), .dly_val(dly_val), .ft_remain(ft_remain),
      .cmp_flags(cmp_flags), .ft_stall(ft_stall), .eof_irq(eof_irq),
      .dly_busy(dly_busy), .dly_remain(dly_remain));

   always @(posedge clk) begin
      if (!rst_n) begin
         m_cnt = 0; m_pre = 0; m_dly = 0; m_run = 0; m_irq = 0; m_flags = 2'b00;
      end else begin
         bit old_run, step;
         int old_cnt;
         old_run = m_run; old_cnt = m_cnt;
         step = old_run && us_tick && !ft_start && (m_pre == FT_DIV - 1);
         if (ft_cmp) m_flags = (old_cnt < int'(ft_cmp_val)) ? 2'b01 : 2'b10;
         if (ft_start) m_pre = 0;
         else if (old_run && us_tick) m_pre = (m_pre == FT_DIV - 1) ? 0 : m_pre + 1;
         m_irq = 0;
         if (ft_load) begin
            m_cnt = int'(ft_load_val); m_run = ft_start;
         end else begin
            if (ft_start) m_run = 1;
            if (step && old_cnt != 0) begin
               if (old_cnt == 1) begin m_irq = eof_irq_en; m_run = 0; end
               m_cnt = old_cnt - 1;
            end
         end
         if (dly_load) m_dly = int'(dly_val);
         else if (us_tick && m_dly != 0) m_dly = m_dly - 1;
      end
   end

   task automatic chk(string tag, int act, int exp);
      tests++;
      if (act != exp) begin
         fails++;
         $display("FAIL %s actual=%0d expected=%0d at %0t", tag, act, exp, $time);
      end
   endtask

   // every-cycle comparison against the model, away from the active edge
   always @(negedge clk) if (rst_n && !done) begin
      chk("R2/R3/R4 frame count", int'(ft_remain), m_cnt);
      chk("R6 flags", int'(cmp_flags), int'(m_flags));
      chk("R5 irq", int'(eof_irq), int'(m_irq));
      chk("R7 stall", int'(ft_stall), int'(ft_wait && m_cnt != 0));
      chk("R8 delay count", int'(dly_remain), m_dly);
      chk("R8 delay busy", int'(dly_busy), int'(m_dly != 0));
   end

   task automatic cyc(int n = 1);
      repeat (n) @(negedge clk);
   endtask

   task automatic clear_strobes();
      ft_load = 0; ft_start = 0; ft_cmp = 0; dly_load = 0;
   endtask

   // tick every 'gap' cycles for n ticks
   task automatic ticks(int n, int gap = 1);
      for (int i = 0; i < n; i++) begin
         us_tick = 1; cyc(1); us_tick = 0; clear_strobes();
         if (gap > 1) cyc(gap - 1);
      end
   endtask

   task automatic compare_at(int v);
      ft_cmp = 1; ft_cmp_val = FT_W'(v); cyc(1); ft_cmp = 0;
   endtask

   initial begin
      int irq_seen;
      cyc(3);
      // R1 reset values
      chk("R1 reset count", int'(ft_remain), 0);
      chk("R1 reset flags", int'(cmp_flags), 0);
      chk("R1 reset irq", int'(eof_irq), 0);
      chk("R1 reset delay", int'(dly_remain), 0);
      rst_n = 1; cyc(1);

      // R2: load without start holds under ticks
      ft_load = 1; ft_load_val = 16'd10; cyc(1); clear_strobes();
      ticks(250);
      chk("R2 held after load", int'(ft_remain), 10);
      // R6 compare on stopped timer
      compare_at(10); chk("R6 equal gives GE", int'(cmp_flags), 2);
      compare_at(11); chk("R6 above gives LT", int'(cmp_flags), 1);
      cyc(5); chk("R6 flags held", int'(cmp_flags), 1);

      // R3: start with coincident tick, then 99 / 100 ticks
      eof_irq_en = 1;
      ft_start = 1; us_tick = 1; cyc(1); us_tick = 0; clear_strobes();
      ticks(99);
      chk("R3 no step at 99 ticks", int'(ft_remain), 10);
      ticks(1);
      chk("R3 step at 100 ticks", int'(ft_remain), 9);
      ft_wait = 1; cyc(1);
      chk("R7 stall while nonzero", int'(ft_stall), 1);
      compare_at(9); chk("R6 running equal GE", int'(cmp_flags), 2);
      // run down to zero with sparse ticks partway
      ticks(300, 2);
      irq_seen = 0;
      while (ft_remain != 0) begin
         ticks(1);
         if (eof_irq) irq_seen++;
      end
      chk("R5 irq in cycle after zero", int'(eof_irq), 1);
      cyc(1);
      chk("R5 irq one cycle", int'(eof_irq), 0);
      chk("R7 stall released", int'(ft_stall), 0);
      ft_wait = 0;
      ticks(400);
      chk("R4 no wrap", int'(ft_remain), 0);
      compare_at(0); chk("R6 zero vs zero GE", int'(cmp_flags), 2);
      compare_at(1); chk("R6 zero vs one LT", int'(cmp_flags), 1);

      // R2: load+start together, irq disabled
      eof_irq_en = 0;
      ft_load = 1; ft_start = 1; ft_load_val = 16'd3; cyc(1); clear_strobes();
      ticks(FT_DIV * 3 + 20);
      chk("R2 load+start ran out", int'(ft_remain), 0);
      chk("R5 no irq when disabled", int'(eof_irq), 0);

      // R5: load zero with irq enabled gives no pulse
      eof_irq_en = 1;
      ft_load = 1; ft_start = 1; ft_load_val = 16'd0; cyc(1); clear_strobes();
      ticks(150);
      chk("R5 no irq on zero load", int'(eof_irq), 0);

      // R2: reload mid-run stops counting
      ft_load = 1; ft_start = 1; ft_load_val = 16'd5; cyc(1); clear_strobes();
      ticks(150);
      ft_load = 1; ft_load_val = 16'd7; cyc(1); clear_strobes();
      ticks(300);
      chk("R2 reload stops timer", int'(ft_remain), 7);

      // R8 delay counter
      dly_load = 1; dly_val = 16'd5; us_tick = 1; cyc(1); us_tick = 0; clear_strobes();
      chk("R8 load beats tick", int'(dly_remain), 5);
      ticks(4);
      chk("R8 busy before expiry", int'(dly_busy), 1);
      ticks(1);
      chk("R8 idle at zero", int'(dly_busy), 0);
      ticks(3);
      chk("R8 no wrap", int'(dly_remain), 0);
      dly_load = 1; dly_val = 16'd300; cyc(1); clear_strobes();
      dly_load = 1; dly_val = 16'd0; cyc(1); clear_strobes();
      chk("R8 zero load idle", int'(dly_busy), 0);

      // mixed pseudo-random phase checked by the model
      for (int i = 0; i < 20000; i++) begin
         us_tick    = ($urandom_range(0, 3) != 0);
         ft_load    = ($urandom_range(0, 2999) == 0);
         ft_load_val = FT_W'($urandom_range(0, 12));
         ft_start   = ($urandom_range(0, 1999) == 0);
         ft_cmp     = ($urandom_range(0, 49) == 0);
         ft_cmp_val = FT_W'($urandom_range(0, 12));
         ft_wait    = ($urandom_range(0, 1) == 0);
         eof_irq_en = ($urandom_range(0, 3) != 0);
         dly_load   = ($urandom_range(0, 299) == 0);
         dly_val    = DLY_W'($urandom_range(0, 400));
         cyc(1);
      end
      clear_strobes();
      cyc(2);
      done = 1;
      $display("[TB] %0d tests run, %0d failed", tests, fails);
      $finish;
   end

   initial begin
      repeat (150000) @(posedge clk);
      if (!done) begin
         done = 1;
         tests++; fails++;
         $display("FAIL watchdog expired");
         $display("[TB] %0d tests run, %0d failed", tests, fails);
         $finish;
      end
   end
endmodule